// File: doc/BRIEF.md
# Pin Interrupt Redirection Controller

The block watches a parameterized set of interrupt input pins and turns their activity into interrupt messages. Each pin owns a programmable routing entry that holds an 8-bit vector, a 3-bit delivery mode, a polarity bit, a trigger-mode bit, a mask bit and a 16-bit destination. Any pin may be edge-sensitive or level-sensitive. A level-sensitive pin holds off after it sends until software acknowledges the vector. The acknowledge matches every level entry that carries that vector, so several level pins of the same polarity can share one vector.

Software reaches the controller through two words. One is a select register and the other is a data port that reads or writes the word the select names. A separate end-of-interrupt strobe carries the vector being acknowledged. Each message leaves on a valid/ready port that holds one message at a time. Input pins are synchronized by two flops, then inverted where they are programmed active-low.

Top module: `irc_top`

## Requirements
- R1: After reset every entry is masked. Its low word reads 0x0001_0000, its high word reads 0, and no message is valid.
- R2: Select value 0x01 reads the identification word. Bits 7:0 hold the VERSION parameter, bits 23:16 hold NUM_PINS-1, and all other bits are zero.
- R3: Select value 0x10+2n addresses the low word of pin n and 0x11+2n its high word. Low word fields: vector 7:0, delivery mode 10:8, active-low polarity 13, remote-pending 14 (read-only), level trigger 15, mask 16. High word: destination 31:16, with the ID in 31:24 and the extended ID in 23:16.
- R4: A high-word write is held staged and reads back at once, but messages keep the old destination until the next low-word write to that pin commits it.
- R5: An unmasked edge pin sends exactly one message per rising active edge. The message is valid after the third rising clock edge following the pin change.
- R6: An active edge that arrives while the pin is masked is dropped, and a later unmask does not produce a message for it.
- R7: An unmasked level pin whose input is active sends one message and sets remote-pending. It sends nothing more while remote-pending is set.
- R8: An end-of-interrupt whose vector matches clears remote-pending on every level entry with that vector. If the input is still active, the pin sends again one cycle later. A vector that does not match leaves the entry unchanged.
- R9: Two level pins that share a vector each send one message, and both stay pending until the single end-of-interrupt for that vector arrives.
- R10: With polarity set to active-low, a low input is active and a high input is idle.
- R11: When several pins request, the lowest-numbered pin is served first. Only one message is outstanding at a time, and it stays valid and stable until msg_ready is accepted.
- R12: A message carries the vector, the committed destination and the delivery mode of its entry. Mode codes are fixed 0, lowest-priority 1, PMI 2 and INIT 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| pin_in | input | NUM_PINS | Raw interrupt input pins |
| cfg_wr | input | 1 | Register write strobe |
| cfg_sel | input | 1 | 0 writes the select register, 1 writes the data port |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Word named by the select register |
| eoi_wr | input | 1 | End-of-interrupt strobe |
| eoi_vector | input | 8 | Vector being acknowledged |
| msg_valid | output | 1 | Message present |
| msg_ready | input | 1 | Receiver accepts the message |
| msg_vector | output | 8 | Message vector |
| msg_dest | output | 16 | Message destination |
| msg_mode | output | 3 | Message delivery mode |

## Verification
A pin change is visible to the request logic after two synchronizer edges, and the message register loads on the third edge. The bench therefore checks that msg_valid is still low after two edges and high after three. A handshake frees the register on one edge, and the next waiting request loads on the following edge. An end-of-interrupt clears remote-pending on its own edge, so a resent message is due one edge later. A register write takes effect on the edge that samples it. Every check is made at the falling edge after the cycle computed this way, never by polling.

// File: rtl/irc_pkg.sv
package irc_pkg;
  localparam int VEC_W  = 8;
  localparam int MODE_W = 3;
  localparam int DEST_W = 16;

  localparam logic [7:0] SEL_IDENT      = 8'h01;
  localparam logic [7:0] SEL_TABLE_BASE = 8'h10;

  typedef enum logic [MODE_W-1:0] {
    DM_FIXED  = 3'd0,
    DM_LOWEST = 3'd1,
    DM_PMI    = 3'd2,
    DM_INIT   = 3'd5
  } irc_dmode_e;

  typedef struct packed {
    logic              mask;
    logic              level;
    logic              act_low;
    logic [MODE_W-1:0] mode;
    logic [VEC_W-1:0]  vector;
  } irc_entry_t;
endpackage

// File: rtl/irc_sync_pol.sv
module irc_sync_pol (
  input  logic clk,
  input  logic rst_n,
  input  logic raw,
  input  logic act_low,
  output logic active
);
  logic [1:0] stage_q, stage_nxt;

  always_comb stage_nxt = {stage_q[0], raw};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= stage_nxt;
  end

  assign active = stage_q[1] ^ act_low;
endmodule

// File: rtl/irc_pin_ctl.sv
module irc_pin_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic active,
  input  logic mask,
  input  logic level,
  input  logic eoi_hit,
  input  logic grant,
  output logic req,
  output logic remote
);
  logic active_d_q, pend_q, remote_q;
  logic active_d_nxt, pend_nxt, remote_nxt;
  logic edge_now;

  assign edge_now = active & ~active_d_q;

  always_comb begin
    active_d_nxt = active;
    if (mask || level) pend_nxt = 1'b0;
    else               pend_nxt = (pend_q | edge_now) & ~grant;
    remote_nxt = remote_q;
    if (!level)       remote_nxt = 1'b0;
    else if (grant)   remote_nxt = 1'b1;
    else if (eoi_hit) remote_nxt = 1'b0;
    if (mask)       req = 1'b0;
    else if (level) req = active & ~remote_q;
    else            req = pend_q | edge_now;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_d_q <= 1'b0;
      pend_q     <= 1'b0;
      remote_q   <= 1'b0;
    end else begin
      active_d_q <= active_d_nxt;
      pend_q     <= pend_nxt;
      remote_q   <= remote_nxt;
    end
  end

  assign remote = remote_q;

  a_r7_remote_after_send: assert property (@(posedge clk) disable iff (!rst_n)
    (grant && level) |=> (remote_q || !level));
  a_r8_eoi_clears_remote: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi_hit && !grant) |=> !remote_q);
  a_r6_masked_edge_dropped: assert property (@(posedge clk) disable iff (!rst_n)
    (mask && !level) |=> !pend_q);
endmodule

// File: rtl/irc_msg_arb.sv
module irc_msg_arb #(
  parameter int NUM_PINS = 8,
  parameter int VEC_W    = 8,
  parameter int DEST_W   = 16,
  parameter int MODE_W   = 3
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NUM_PINS-1:0]        req,
  input  logic [NUM_PINS*VEC_W-1:0]  vec_flat,
  input  logic [NUM_PINS*DEST_W-1:0] dest_flat,
  input  logic [NUM_PINS*MODE_W-1:0] mode_flat,
  input  logic                       msg_ready,
  output logic [NUM_PINS-1:0]        grant,
  output logic                       msg_valid,
  output logic [VEC_W-1:0]           msg_vector,
  output logic [DEST_W-1:0]          msg_dest,
  output logic [MODE_W-1:0]          msg_mode
);
  localparam int IDX_W = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1;

  logic [IDX_W-1:0]  pick;
  logic              any_req, load;
  logic              valid_q, valid_nxt;
  logic [VEC_W-1:0]  vec_q, vec_nxt;
  logic [DEST_W-1:0] dest_q, dest_nxt;
  logic [MODE_W-1:0] mode_q, mode_nxt;

  always_comb begin
    pick = '0;
    for (int i = NUM_PINS-1; i >= 0; i--) begin
      if (req[i]) pick = IDX_W'(i);
    end
  end

  assign any_req = |req;
  assign load    = ~valid_q & any_req;

  generate
    for (genvar g = 0; g < NUM_PINS; g++) begin : g_grant
      assign grant[g] = load && (pick == IDX_W'(g));
    end
  endgenerate

  always_comb begin
    valid_nxt = valid_q ? ~msg_ready : any_req;
    vec_nxt   = vec_q;
    dest_nxt  = dest_q;
    mode_nxt  = mode_q;
    if (load) begin
      vec_nxt  = vec_flat[pick*VEC_W +: VEC_W];
      dest_nxt = dest_flat[pick*DEST_W +: DEST_W];
      mode_nxt = mode_flat[pick*MODE_W +: MODE_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      vec_q   <= '0;
      dest_q  <= '0;
      mode_q  <= '0;
    end else begin
      valid_q <= valid_nxt;
      if (load) begin
        vec_q  <= vec_nxt;
        dest_q <= dest_nxt;
        mode_q <= mode_nxt;
      end
    end
  end

  assign msg_valid  = valid_q;
  assign msg_vector = vec_q;
  assign msg_dest   = dest_q;
  assign msg_mode   = mode_q;

  a_r11_one_grant: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));
  a_r11_grant_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
    (grant & ~req) == '0);
  a_r11_hold_until_ready: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_q && !msg_ready) |=> (valid_q && $stable(vec_q) && $stable(dest_q) && $stable(mode_q)));
endmodule

// File: rtl/irc_top.sv
module irc_top
  import irc_pkg::*;
#(
  parameter int         NUM_PINS = 8,
  parameter logic [7:0] VERSION  = 8'h21
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PINS-1:0] pin_in,
  input  logic                cfg_wr,
  input  logic                cfg_sel,
  input  logic [31:0]         cfg_wdata,
  output logic [31:0]         cfg_rdata,
  input  logic                eoi_wr,
  input  logic [7:0]          eoi_vector,
  output logic                msg_valid,
  input  logic                msg_ready,
  output logic [7:0]          msg_vector,
  output logic [15:0]         msg_dest,
  output logic [2:0]          msg_mode
);
  localparam logic [7:0] MAX_PIN = 8'(NUM_PINS-1);
  localparam logic [8:0] TBL_END = 9'(SEL_TABLE_BASE) + 9'(2*NUM_PINS);

  logic [1:0] rst_pipe_q;
  logic       rst_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_s = rst_pipe_q[1];

  logic [7:0] sel_q, sel_nxt;
  logic       in_table, hi_word;
  logic [7:0] sel_off;
  logic [6:0] tbl_idx;
  logic       data_wr;

  assign in_table = ({1'b0, sel_q} >= {1'b0, SEL_TABLE_BASE}) && ({1'b0, sel_q} < TBL_END);
  assign sel_off  = sel_q - SEL_TABLE_BASE;
  assign tbl_idx  = sel_off[7:1];
  assign hi_word  = sel_off[0];
  assign data_wr  = cfg_wr & cfg_sel & in_table;

  always_comb sel_nxt = (cfg_wr && !cfg_sel) ? cfg_wdata[7:0] : sel_q;

  irc_entry_t          ent_q     [NUM_PINS];
  irc_entry_t          ent_nxt   [NUM_PINS];
  logic [DEST_W-1:0]   dest_q    [NUM_PINS];
  logic [DEST_W-1:0]   dest_nxt  [NUM_PINS];
  logic [DEST_W-1:0]   stage_q   [NUM_PINS];
  logic [DEST_W-1:0]   stage_nxt [NUM_PINS];

  always_comb begin
    for (int i = 0; i < NUM_PINS; i++) begin
      ent_nxt[i]   = ent_q[i];
      dest_nxt[i]  = dest_q[i];
      stage_nxt[i] = stage_q[i];
      if (data_wr && (tbl_idx == 7'(i))) begin
        if (hi_word) begin
          stage_nxt[i] = cfg_wdata[31:16];
        end else begin
          ent_nxt[i].vector  = cfg_wdata[7:0];
          ent_nxt[i].mode    = cfg_wdata[10:8];
          ent_nxt[i].act_low = cfg_wdata[13];
          ent_nxt[i].level   = cfg_wdata[15];
          ent_nxt[i].mask    = cfg_wdata[16];
          dest_nxt[i]        = stage_q[i];
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      sel_q <= '0;
      for (int i = 0; i < NUM_PINS; i++) begin
        ent_q[i]   <= '{mask: 1'b1, default: '0};
        dest_q[i]  <= '0;
        stage_q[i] <= '0;
      end
    end else begin
      sel_q <= sel_nxt;
      if (data_wr) begin
        for (int i = 0; i < NUM_PINS; i++) begin
          ent_q[i]   <= ent_nxt[i];
          dest_q[i]  <= dest_nxt[i];
          stage_q[i] <= stage_nxt[i];
        end
      end
    end
  end

  logic [NUM_PINS-1:0]        active_w, req_w, remote_w, grant_w, eoi_hit_w;
  logic [NUM_PINS*VEC_W-1:0]  vec_flat;
  logic [NUM_PINS*DEST_W-1:0] dest_flat;
  logic [NUM_PINS*MODE_W-1:0] mode_flat;

  generate
    for (genvar g = 0; g < NUM_PINS; g++) begin : g_pin
      assign eoi_hit_w[g] = eoi_wr && (ent_q[g].vector == eoi_vector);
      assign vec_flat[g*VEC_W +: VEC_W]    = ent_q[g].vector;
      assign dest_flat[g*DEST_W +: DEST_W] = dest_q[g];
      assign mode_flat[g*MODE_W +: MODE_W] = ent_q[g].mode;

      irc_sync_pol u_sync (
        .clk     (clk),
        .rst_n   (rst_s),
        .raw     (pin_in[g]),
        .act_low (ent_q[g].act_low),
        .active  (active_w[g])
      );

      irc_pin_ctl u_ctl (
        .clk     (clk),
        .rst_n   (rst_s),
        .active  (active_w[g]),
        .mask    (ent_q[g].mask),
        .level   (ent_q[g].level),
        .eoi_hit (eoi_hit_w[g]),
        .grant   (grant_w[g]),
        .req     (req_w[g]),
        .remote  (remote_w[g])
      );
    end
  endgenerate

  irc_msg_arb #(
    .NUM_PINS (NUM_PINS),
    .VEC_W    (VEC_W),
    .DEST_W   (DEST_W),
    .MODE_W   (MODE_W)
  ) u_arb (
    .clk        (clk),
    .rst_n      (rst_s),
    .req        (req_w),
    .vec_flat   (vec_flat),
    .dest_flat  (dest_flat),
    .mode_flat  (mode_flat),
    .msg_ready  (msg_ready),
    .grant      (grant_w),
    .msg_valid  (msg_valid),
    .msg_vector (msg_vector),
    .msg_dest   (msg_dest),
    .msg_mode   (msg_mode)
  );

  always_comb begin
    cfg_rdata = '0;
    if (sel_q == SEL_IDENT) begin
      cfg_rdata = {8'h00, MAX_PIN, 8'h00, VERSION};
    end else if (in_table) begin
      for (int i = 0; i < NUM_PINS; i++) begin
        if (tbl_idx == 7'(i)) begin
          if (hi_word)
            cfg_rdata = {stage_q[i], 16'h0000};
          else
            cfg_rdata = {15'b0, ent_q[i].mask, ent_q[i].level, remote_w[i],
                         ent_q[i].act_low, 2'b00, ent_q[i].mode, ent_q[i].vector};
        end
      end
    end
  end

  logic unused_wdata;
  assign unused_wdata = ^{cfg_wdata[12:11], cfg_wdata[14], cfg_wdata[31:17]};

  a_r11_msg_from_request: assert property (@(posedge clk) disable iff (!rst_s)
    $rose(msg_valid) |-> $past(|req_w));
  a_r1_quiet_after_reset: assert property (@(posedge clk) disable iff (!rst_s)
    $rose(rst_s) |-> !msg_valid);
endmodule

// File: tb/irc_top_test.sv
module irc_top_test;
  import irc_pkg::*;

  localparam int NP = 8;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [NP-1:0] pin_in;
  logic          cfg_wr, cfg_sel, eoi_wr, msg_ready;
  logic [31:0]   cfg_wdata, cfg_rdata;
  logic [7:0]    eoi_vector, msg_vector;
  logic          msg_valid;
  logic [15:0]   msg_dest;
  logic [2:0]    msg_mode;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  irc_top #(.NUM_PINS(NP), .VERSION(8'h21)) uut (
    .clk(clk), .rst_n(rst_n), .pin_in(pin_in),
    .cfg_wr(cfg_wr), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .eoi_wr(eoi_wr), .eoi_vector(eoi_vector),
    .msg_valid(msg_valid), .msg_ready(msg_ready),
    .msg_vector(msg_vector), .msg_dest(msg_dest), .msg_mode(msg_mode)
  );

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", rq, act, exp);
    end
  endtask

  function automatic logic [31:0] lo_word(input logic [7:0] v, input logic [2:0] m,
                                          input logic pol, input logic lvl, input logic msk);
    return {15'b0, msk, lvl, 1'b0, pol, 2'b00, m, v};
  endfunction

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic s, input logic [31:0] d);
    cfg_wr = 1'b1; cfg_sel = s; cfg_wdata = d;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] sel, output logic [31:0] d);
    wr(1'b0, {24'h0, sel});
    d = cfg_rdata;
  endtask

  task automatic prog(input int n, input logic [31:0] lo, input logic [31:0] hi);
    wr(1'b0, 32'(8'h11 + 2*n));
    wr(1'b1, hi);
    wr(1'b0, 32'(8'h10 + 2*n));
    wr(1'b1, lo);
  endtask

  task automatic pop();
    msg_ready = 1'b1;
    @(negedge clk);
    msg_ready = 1'b0;
  endtask

  task automatic eoi(input logic [7:0] v);
    eoi_wr = 1'b1; eoi_vector = v;
    @(negedge clk);
    eoi_wr = 1'b0;
  endtask

  task automatic expect_msg(input string rq, input logic [7:0] v, input logic [15:0] d,
                            input logic [2:0] m);
    chk({rq, " valid"}, 32'(msg_valid), 32'd1);
    chk({rq, " vector"}, 32'(msg_vector), 32'(v));
    chk({rq, " dest"}, 32'(msg_dest), 32'(d));
    chk({rq, " mode"}, 32'(msg_mode), 32'(m));
  endtask

  task automatic t_reset();
    logic [31:0] d;
    chk("R1 no message", 32'(msg_valid), 32'd0);
    rd(8'h10, d); chk("R1 R3 pin0 low masked", d, 32'h0001_0000);
    rd(8'h1F, d); chk("R1 R3 pin7 high", d, 32'h0);
    rd(8'h1E, d); chk("R1 pin7 low masked", d, 32'h0001_0000);
  endtask

  task automatic t_ident();
    logic [31:0] d;
    rd(8'h01, d); chk("R2 ident word", d, 32'h0007_0021);
  endtask

  task automatic t_edge_commit();
    logic [31:0] d;
    prog(0, lo_word(8'h30, DM_LOWEST, 1'b0, 1'b0, 1'b0), 32'h1234_0000);
    rd(8'h10, d); chk("R3 low readback", d, lo_word(8'h30, DM_LOWEST, 1'b0, 1'b0, 1'b0));
    pin_in[0] = 1'b1;
    step(2); chk("R5 not yet valid", 32'(msg_valid), 32'd0);
    step(1); expect_msg("R5 R12 edge msg", 8'h30, 16'h1234, DM_LOWEST);
    step(2); expect_msg("R11 held", 8'h30, 16'h1234, DM_LOWEST);
    pop();
    step(3); chk("R5 single message", 32'(msg_valid), 32'd0);
    pin_in[0] = 1'b0;
    wr(1'b0, 32'h11); wr(1'b1, 32'hABCD_0000);
    rd(8'h11, d); chk("R3 R4 staged high readback", d, 32'hABCD_0000);
    pin_in[0] = 1'b1;
    step(3); expect_msg("R4 old dest before commit", 8'h30, 16'h1234, DM_LOWEST);
    pop();
    pin_in[0] = 1'b0;
    wr(1'b0, 32'h10); wr(1'b1, lo_word(8'h30, DM_LOWEST, 1'b0, 1'b0, 1'b0));
    pin_in[0] = 1'b1;
    step(3); expect_msg("R4 new dest after commit", 8'h30, 16'hABCD, DM_LOWEST);
    pop();
    pin_in[0] = 1'b0;
    prog(0, lo_word(8'h30, DM_FIXED, 1'b0, 1'b0, 1'b1), 32'h0);
  endtask

  task automatic t_masked_edge();
    prog(1, lo_word(8'h31, DM_FIXED, 1'b0, 1'b0, 1'b1), 32'h0100_0000);
    pin_in[1] = 1'b1;
    step(5); chk("R6 masked edge silent", 32'(msg_valid), 32'd0);
    prog(1, lo_word(8'h31, DM_FIXED, 1'b0, 1'b0, 1'b0), 32'h0100_0000);
    step(5); chk("R6 unmask no late message", 32'(msg_valid), 32'd0);
    pin_in[1] = 1'b0;
    step(3);
    pin_in[1] = 1'b1;
    step(3); expect_msg("R6 fresh edge after unmask", 8'h31, 16'h0100, DM_FIXED);
    pop();
    pin_in[1] = 1'b0;
    prog(1, lo_word(8'h31, DM_FIXED, 1'b0, 1'b0, 1'b1), 32'h0);
  endtask

  task automatic t_level();
    logic [31:0] d;
    prog(2, lo_word(8'h42, DM_FIXED, 1'b0, 1'b1, 1'b0), 32'h0200_0000);
    pin_in[2] = 1'b1;
    step(3); expect_msg("R7 level msg", 8'h42, 16'h0200, DM_FIXED);
    pop();
    step(4); chk("R7 no repeat while pending", 32'(msg_valid), 32'd0);
    rd(8'h14, d); chk("R7 remote bit set", d, lo_word(8'h42, DM_FIXED, 1'b0, 1'b1, 1'b0) | 32'h4000);
    eoi(8'h43);
    rd(8'h14, d); chk("R8 wrong vector keeps remote", d, lo_word(8'h42, DM_FIXED, 1'b0, 1'b1, 1'b0) | 32'h4000);
    chk("R8 wrong vector no message", 32'(msg_valid), 32'd0);
    eoi(8'h42);
    step(1); expect_msg("R8 resend after eoi", 8'h42, 16'h0200, DM_FIXED);
    pop();
    pin_in[2] = 1'b0;
    step(3);
    eoi(8'h42);
    step(3); chk("R8 idle input no resend", 32'(msg_valid), 32'd0);
    rd(8'h14, d); chk("R8 remote cleared", d, lo_word(8'h42, DM_FIXED, 1'b0, 1'b1, 1'b0));
  endtask

  task automatic t_shared();
    logic [31:0] d;
    prog(2, lo_word(8'h50, DM_FIXED, 1'b0, 1'b1, 1'b0), 32'h0200_0000);
    prog(3, lo_word(8'h50, DM_FIXED, 1'b0, 1'b1, 1'b0), 32'h0300_0000);
    pin_in[2] = 1'b1; pin_in[3] = 1'b1;
    step(3); expect_msg("R9 R11 shared first", 8'h50, 16'h0200, DM_FIXED);
    pop();
    step(1); expect_msg("R9 shared second", 8'h50, 16'h0300, DM_FIXED);
    pop();
    step(3); chk("R9 both pending silent", 32'(msg_valid), 32'd0);
    rd(8'h14, d); chk("R9 pin2 remote", 32'(d[14]), 32'd1);
    rd(8'h16, d); chk("R9 pin3 remote", 32'(d[14]), 32'd1);
    eoi(8'h50);
    step(1); expect_msg("R9 first after eoi", 8'h50, 16'h0200, DM_FIXED);
    pop();
    step(1); expect_msg("R9 second after eoi", 8'h50, 16'h0300, DM_FIXED);
    pop();
    pin_in[2] = 1'b0; pin_in[3] = 1'b0;
    step(3);
    eoi(8'h50);
    prog(2, lo_word(8'h50, DM_FIXED, 1'b0, 1'b1, 1'b1), 32'h0);
    prog(3, lo_word(8'h50, DM_FIXED, 1'b0, 1'b1, 1'b1), 32'h0);
  endtask

  task automatic t_polarity();
    pin_in[4] = 1'b1;
    step(3);
    prog(4, lo_word(8'h64, DM_FIXED, 1'b1, 1'b1, 1'b0), 32'h0400_0000);
    step(4); chk("R10 high is idle", 32'(msg_valid), 32'd0);
    pin_in[4] = 1'b0;
    step(2); chk("R10 not yet valid", 32'(msg_valid), 32'd0);
    step(1); expect_msg("R10 low is active", 8'h64, 16'h0400, DM_FIXED);
    pop();
    pin_in[4] = 1'b1;
    step(3);
    eoi(8'h64);
    step(3); chk("R10 released no resend", 32'(msg_valid), 32'd0);
  endtask

  task automatic t_priority();
    prog(6, lo_word(8'h66, DM_INIT, 1'b0, 1'b0, 1'b0), 32'h0600_0000);
    prog(5, lo_word(8'h55, DM_PMI, 1'b0, 1'b0, 1'b0), 32'h0500_0000);
    pin_in[5] = 1'b1; pin_in[6] = 1'b1;
    step(3); expect_msg("R11 R12 lowest pin first", 8'h55, 16'h0500, DM_PMI);
    step(3); expect_msg("R11 stable while stalled", 8'h55, 16'h0500, DM_PMI);
    pop();
    step(1); expect_msg("R11 R12 next pin", 8'h66, 16'h0600, DM_INIT);
    pop();
    step(3); chk("R11 queue drained", 32'(msg_valid), 32'd0);
  endtask

  initial begin
    #800000;
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; pin_in = '0; cfg_wr = 1'b0; cfg_sel = 1'b0; cfg_wdata = '0;
    eoi_wr = 1'b0; eoi_vector = '0; msg_ready = 1'b0;
    step(4);
    rst_n = 1'b1;
    step(4);
    t_reset();
    t_ident();
    t_edge_commit();
    t_masked_edge();
    t_level();
    t_shared();
    t_polarity();
    t_priority();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule